// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This unit watches a live BCD calendar and raises an alarm when the calendar agrees with a set of programmed alarm fields. There are seven fields: second, minute, hour, date, month, day of week and year. Each field register holds a compare value and an enable flag in its top bit. A field whose flag is clear is ignored in the comparison. The comparison runs only when the one-second tick arrives, so a match that lasts for a whole second is seen once.

A control register has two bits. The mode bit chooses between a latched single-event alarm and a pulsed interrupt alarm. The frequency-output bit takes the shared pin for another use, and while it is set the alarm is suspended. When an alarm fires, a status bit is set and the open-drain interrupt pin is pulled low. In single-event mode the pin stays low until software clears the status. In interrupt mode the pin is held low only for a fixed number of ticks of a faster timebase, and the status bit stays set.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, all seven field registers and the control register read as zero, the status bit is 0 and the pin is released.
- R2: Register addresses 0 to 6 select the fields in the order second, minute, hour, date, month, day of week, year. In these registers, bit 8 is the enable and bits 7:0 hold the BCD compare value. Address 7 is control: bit 0 is the mode (0 single-event, 1 interrupt) and bit 1 is the frequency-output enable. Control bits 8:2 read back as 0.
- R3: A match needs every enabled field to equal its calendar byte. Disabled fields do not take part in the comparison.
- R4: If no field is enabled, the alarm never fires.
- R5: Matching is evaluated only in a cycle where the 1 Hz tick is high. A match with no tick leaves the status bit and the pin unchanged.
- R6: In single-event mode, a firing sets the status bit and pulls the pin low from the next cycle onward. Both hold until a status-clear strobe, and both are released in the cycle after that strobe.
- R7: In interrupt mode, a firing sets the status bit and pulls the pin low. The pin is released right after the PULSE_TICKS-th fast tick that follows the firing. The status bit stays set until it is cleared.
- R8: While the frequency-output enable is 1, no alarm fires and the pin is released. A status bit that is already set keeps its value.
- R9: If a firing and a status-clear strobe occur in the same cycle, the status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second that starts a comparison |
| tick_fast | input | 1 | One-cycle pulse of the faster timebase that times the interrupt pulse |
| cal_bcd | input | 56 | Live calendar, byte k at bits 8k+7:8k, in field order of R2 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 9 | Register write data |
| reg_rdata | output | 9 | Register read data for reg_addr (combinational) |
| stat_clr | input | 1 | Status-clear strobe |
| alarm_stat | output | 1 | Alarm status bit |
| irq_pull_low | output | 1 | Open-drain pin control: 1 pulls the pin low, 0 releases it; the pin is never driven high |

## Verification
The hardest cases to reach are those where two events coincide or where one state overrides another. Examples are a firing in the same cycle as a clear, and the frequency-output bit being set while a single-event alarm is already latched. In both cases the pin must follow the override, not the status bit. The bench reaches these by scheduling the 1 Hz tick, the clear strobe and the control writes on chosen cycles. It places the fast-tick pulses one at a time, so the check of the pin lands just before and just after the final tick of an interrupt pulse.

// File: rtl/almu_pkg.sv
package almu_pkg;
   localparam int ALM_FIELDS  = 7;
   localparam int ALM_FIELD_W = 8;

   typedef struct packed {
      logic fout_en;
      logic irq_mode;
   } almu_ctrl_t;

   localparam int ALMU_CTRL_W = $bits(almu_ctrl_t);
endpackage

// File: rtl/almu_regs.sv
module almu_regs
   import almu_pkg::*;
#(
   parameter int NUM_FIELDS = ALM_FIELDS,
   parameter int FIELD_W    = ALM_FIELD_W,
   parameter int ADDR_W     = $clog2(NUM_FIELDS + 1)
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [FIELD_W:0]              wdata,
   output logic [FIELD_W:0]              rdata,
   output logic [NUM_FIELDS-1:0]         fld_en,
   output logic [NUM_FIELDS*FIELD_W-1:0] fld_val,
   output almu_ctrl_t                    ctrl
);
   localparam int CTRL_ADDR = NUM_FIELDS;
   localparam int PAD_W     = FIELD_W + 1 - ALMU_CTRL_W;

   generate
      if (FIELD_W < ALMU_CTRL_W) begin : g_bad_width
         $error("almu_regs: FIELD_W too small for control register");
      end
      if ((1 << ADDR_W) < NUM_FIELDS + 1) begin : g_bad_addr
         $error("almu_regs: ADDR_W cannot reach control register");
      end
   endgenerate

   logic [FIELD_W:0] fld_q [NUM_FIELDS];
   almu_ctrl_t       ctrl_q;

   generate
      for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               fld_q[g] <= '0;
            else if (we && (addr == ADDR_W'(g)))
               fld_q[g] <= wdata;
         end
         assign fld_en[g]                     = fld_q[g][FIELD_W];
         assign fld_val[g*FIELD_W +: FIELD_W] = fld_q[g][FIELD_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (we && (addr == ADDR_W'(CTRL_ADDR)))
         ctrl_q <= wdata[ALMU_CTRL_W-1:0];
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_FIELDS; i++) begin
         if (addr == ADDR_W'(i))
            rdata = fld_q[i];
      end
      if (addr == ADDR_W'(CTRL_ADDR))
         rdata = {{PAD_W{1'b0}}, ctrl_q};
   end

   assign ctrl = ctrl_q;

   // R2: a write to the control address updates only the control register
   assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_W'(CTRL_ADDR)) |=> (ctrl_q == $past(wdata[ALMU_CTRL_W-1:0])));
endmodule

// File: rtl/almu_match.sv
module almu_match #(
   parameter int NUM_FIELDS = 7,
   parameter int FIELD_W    = 8
)(
   input  logic                          tick_1hz,
   input  logic                          fout_en,
   input  logic [NUM_FIELDS-1:0]         fld_en,
   input  logic [NUM_FIELDS*FIELD_W-1:0] fld_val,
   input  logic [NUM_FIELDS*FIELD_W-1:0] cal,
   output logic                          hit
);
   logic [NUM_FIELDS-1:0] field_ok;

   generate
      for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
         assign field_ok[g] = !fld_en[g] ||
                              (fld_val[g*FIELD_W +: FIELD_W] == cal[g*FIELD_W +: FIELD_W]);
      end
   endgenerate

   logic any_en;
   logic all_ok;
   assign any_en = |fld_en;
   assign all_ok = &field_ok;
   assign hit    = tick_1hz && !fout_en && any_en && all_ok;
endmodule

// File: rtl/almu_irq.sv
module almu_irq #(
   parameter int PULSE_TICKS = 16
)(
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic clr,
   input  logic tick_fast,
   input  logic irq_mode,
   input  logic fout_en,
   output logic stat,
   output logic pull_low
);
   localparam int CNT_W = $clog2(PULSE_TICKS + 1);

   generate
      if (PULSE_TICKS < 1) begin : g_bad_pulse
         $error("almu_irq: PULSE_TICKS must be at least 1");
      end
   endgenerate

   logic             stat_q;
   logic [CNT_W-1:0] cnt_q;
   logic             pulse_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stat_q <= 1'b0;
      else if (hit)
         stat_q <= 1'b1;
      else if (clr)
         stat_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (fout_en)
         cnt_q <= '0;
      else if (hit && irq_mode)
         cnt_q <= CNT_W'(PULSE_TICKS);
      else if (tick_fast && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign pulse_on = (cnt_q != '0);
   assign stat     = stat_q;
   assign pull_low = !fout_en && (irq_mode ? pulse_on : stat_q);

   // R6: the status bit holds until a clear strobe arrives
   assert_stat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q && !clr) |=> stat_q);
   // R6: a clear with no competing firing drops the status bit
   assert_stat_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !hit) |=> !stat_q);
   // R9: a firing wins over a clear in the same cycle
   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> stat_q);
   // R7: the pulse counter never exceeds its load value
   assert_pulse_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(PULSE_TICKS));
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
   import almu_pkg::*;
#(
   parameter int NUM_FIELDS  = ALM_FIELDS,
   parameter int FIELD_W     = ALM_FIELD_W,
   parameter int PULSE_TICKS = 16,
   localparam int ADDR_W     = $clog2(NUM_FIELDS + 1),
   localparam int CAL_W      = NUM_FIELDS * FIELD_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              tick_fast,
   input  logic [CAL_W-1:0]  cal_bcd,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [FIELD_W:0]  reg_wdata,
   output logic [FIELD_W:0]  reg_rdata,
   input  logic              stat_clr,
   output logic              alarm_stat,
   output logic              irq_pull_low
);
   generate
      if (NUM_FIELDS < 1) begin : g_bad_fields
         $error("alarm_match_unit: NUM_FIELDS must be at least 1");
      end
   endgenerate

   logic [NUM_FIELDS-1:0] fld_en;
   logic [CAL_W-1:0]      fld_val;
   almu_ctrl_t            ctrl;
   logic                  hit;

   almu_regs #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (reg_we),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .rdata  (reg_rdata),
      .fld_en (fld_en),
      .fld_val(fld_val),
      .ctrl   (ctrl)
   );

   almu_match #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_match (
      .tick_1hz(tick_1hz),
      .fout_en (ctrl.fout_en),
      .fld_en  (fld_en),
      .fld_val (fld_val),
      .cal     (cal_bcd),
      .hit     (hit)
   );

   almu_irq #(.PULSE_TICKS(PULSE_TICKS)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .clr      (stat_clr),
      .tick_fast(tick_fast),
      .irq_mode (ctrl.irq_mode),
      .fout_en  (ctrl.fout_en),
      .stat     (alarm_stat),
      .pull_low (irq_pull_low)
   );

   // R8: frequency output keeps the alarm pin released
   assert_fout_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.fout_en |-> !irq_pull_low);
   // R5: the status bit rises only after a 1 Hz tick
   assert_tick_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_stat) |-> $past(tick_1hz));
   // R4: with no field enabled, no firing is produced
   assert_none_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fld_en == '0) |-> !hit);
endmodule

// File: tb/alarm_match_unit_tb_top.sv
module alarm_match_unit_tb_top;
   localparam int NF    = 7;
   localparam int FW    = 8;
   localparam int PT    = 4;
   localparam int AW    = 3;
   localparam int CAL_W = NF * FW;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick_1hz = 1'b0;
   logic             tick_fast = 1'b0;
   logic [CAL_W-1:0] cal_bcd = '0;
   logic             reg_we = 1'b0;
   logic [AW-1:0]    reg_addr = '0;
   logic [FW:0]      reg_wdata = '0;
   logic [FW:0]      reg_rdata;
   logic             stat_clr = 1'b0;
   logic             alarm_stat;
   logic             irq_pull_low;

   always #10 clk = ~clk;

   alarm_match_unit #(.NUM_FIELDS(NF), .FIELD_W(FW), .PULSE_TICKS(PT)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .tick_fast(tick_fast),
      .cal_bcd(cal_bcd), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_clr(stat_clr),
      .alarm_stat(alarm_stat), .irq_pull_low(irq_pull_low)
   );

   typedef struct {
      bit          is_rd;
      logic [FW:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int    n_cmp  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;

   // monitor: compares pending expectations away from the active edge
   always @(negedge clk) begin
      while (q.size() > 0) begin
         item_t it;
         logic [FW:0] act;
         it  = q.pop_front();
         act = it.is_rd ? reg_rdata : {{(FW-1){1'b0}}, irq_pull_low, alarm_stat};
         n_cmp++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic cyc();
      @(posedge clk);
      #2;
   endtask

   task automatic exp_pin(input bit pd, input bit st, input string tag);
      item_t it;
      it.is_rd = 1'b0;
      it.exp   = {{(FW-1){1'b0}}, pd, st};
      it.tag   = tag;
      q.push_back(it);
   endtask

   task automatic exp_rd(input logic [AW-1:0] a, input logic [FW:0] v, input string tag);
      item_t it;
      reg_addr = a;
      it.is_rd = 1'b1;
      it.exp   = v;
      it.tag   = tag;
      q.push_back(it);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [FW:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      cyc();
      reg_we = 1'b0;
   endtask

   task automatic sec_tick();
      tick_1hz = 1'b1;
      cyc();
      tick_1hz = 1'b0;
   endtask

   task automatic fast_tick();
      tick_fast = 1'b1;
      cyc();
      tick_fast = 1'b0;
   endtask

   task automatic clear();
      stat_clr = 1'b1;
      cyc();
      stat_clr = 1'b0;
   endtask

   task automatic set_cal(input int idx, input logic [FW-1:0] v);
      cal_bcd[idx*FW +: FW] = v;
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      // R1 reset state
      exp_pin(1'b0, 1'b0, "R1 pin/stat after reset");
      cyc();
      exp_rd(3'd0, 9'h000, "R1 field 0 after reset");
      cyc();
      exp_rd(3'd7, 9'h000, "R1 control after reset");
      cyc();

      // R2 register access
      wr(3'd0, 9'h130);
      exp_rd(3'd0, 9'h130, "R2 second field readback");
      cyc();
      wr(3'd6, 9'h099);
      exp_rd(3'd6, 9'h099, "R2 year field readback");
      cyc();
      wr(3'd7, 9'h1FF);
      exp_rd(3'd7, 9'h003, "R2 control readback masks unused bits");
      cyc();
      wr(3'd7, 9'h000);
      wr(3'd6, 9'h000);

      // R5: match present but no tick
      set_cal(0, 8'h30); set_cal(1, 8'h44); set_cal(2, 8'h12);
      repeat (3) cyc();
      exp_pin(1'b0, 1'b0, "R5 match without tick stays idle");
      cyc();

      // R3/R6 single-event firing on second only
      sec_tick();
      exp_pin(1'b1, 1'b1, "R6 single-event fires");
      set_cal(0, 8'h31);
      repeat (4) cyc();
      exp_pin(1'b1, 1'b1, "R6 held after calendar moves");
      cyc();
      clear();
      exp_pin(1'b0, 1'b0, "R6 cleared by strobe");
      cyc();

      // R3 two fields, one mismatching
      wr(3'd1, 9'h145);
      set_cal(0, 8'h30);
      sec_tick();
      exp_pin(1'b0, 1'b0, "R3 minute mismatch blocks alarm");
      cyc();
      set_cal(1, 8'h45); set_cal(2, 8'h23); set_cal(4, 8'h11);
      sec_tick();
      exp_pin(1'b1, 1'b1, "R3 all enabled fields match, others free");
      cyc();
      clear();

      // R3 year field
      wr(3'd0, 9'h000); wr(3'd1, 9'h000);
      wr(3'd6, 9'h199);
      set_cal(6, 8'h98);
      sec_tick();
      exp_pin(1'b0, 1'b0, "R3 year mismatch");
      cyc();
      set_cal(6, 8'h99);
      sec_tick();
      exp_pin(1'b1, 1'b1, "R3 year match");
      cyc();
      clear();

      // R4 nothing enabled: values equal but no enable
      wr(3'd6, 9'h099);
      sec_tick();
      exp_pin(1'b0, 1'b0, "R4 no enabled field never fires");
      cyc();
      wr(3'd6, 9'h000);
      cal_bcd = '0;
      sec_tick();
      exp_pin(1'b0, 1'b0, "R4 all zero without enables");
      cyc();

      // R7 interrupt mode on day of week
      wr(3'd7, 9'h001);
      wr(3'd5, 9'h103);
      set_cal(5, 8'h03);
      sec_tick();
      exp_pin(1'b1, 1'b1, "R7 interrupt pulse starts");
      cyc();
      for (int i = 0; i < PT - 1; i++) fast_tick();
      exp_pin(1'b1, 1'b1, "R7 still low before last fast tick");
      cyc();
      fast_tick();
      exp_pin(1'b0, 1'b1, "R7 released after last fast tick, status kept");
      cyc();
      clear();
      exp_pin(1'b0, 1'b0, "R7 status cleared");
      cyc();

      // R8 frequency output blocks firing
      wr(3'd7, 9'h002);
      sec_tick();
      exp_pin(1'b0, 1'b0, "R8 no firing with frequency output");
      cyc();
      wr(3'd7, 9'h000);
      sec_tick();
      exp_pin(1'b1, 1'b1, "R8 single-event latched before override");
      cyc();
      wr(3'd7, 9'h002);
      exp_pin(1'b0, 1'b1, "R8 pin released, status kept");
      cyc();
      wr(3'd7, 9'h000);
      exp_pin(1'b1, 1'b1, "R8 pin back after override removed");
      cyc();
      clear();

      // R9 firing and clear together
      stat_clr = 1'b1;
      sec_tick();
      stat_clr = 1'b0;
      exp_pin(1'b1, 1'b1, "R9 set wins over clear");
      cyc();
      clear();
      exp_pin(1'b0, 1'b0, "R9 later clear works");
      cyc();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end
endmodule